// File: doc/BRIEF.md
# Converter Test Word Generator

This block sits between a multi-bit sampling converter core and its output serializer. In normal operation it forwards each converter sample unchanged. When a test mode is selected it replaces the samples with deterministic words. A downstream receiver knows these words in advance, so it can check that its bit capture, word framing and timing alignment are correct. The block produces exactly one parallel word per sample strobe. The serializer then shifts that word out, most significant bit first.

The patterns are: a mid-scale word, all ones, all zeros, two alternating patterns, a rotation through four user-programmed words, and two pseudo-random sequences. The short pseudo-random sequence repeats every 511 bits; the long one repeats every 8,388,607 bits and is inverted. A word-length input from 8 to 14 bits shortens every pattern except the two pseudo-random ones, which always fill the full word. Whenever the mode changes, the pseudo-random generators go back to their seeds and the alternating and rotating patterns go back to their first word. The receiver can therefore predict the first word after every switch.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: While rst_ni is low, word_o is 0 and valid_o is 0.
- R2: valid_o is 1 in exactly the cycle after each cycle with strobe_i high. word_o changes only in the cycle after a strobe and otherwise holds its value.
- R3: mode_i = 0 passes sample_i to word_o unchanged, regardless of word_len_i.
- R4: Fixed modes: mode 1 gives 14'h2000, mode 2 gives 14'h3FFF, mode 3 gives 14'h0000. Each is then shortened as described in R5.
- R5: In modes 1, 2, 3, 4, 7 and 8, the 14-bit pattern word is right-shifted by (14 - L), so it keeps its top L bits and all bits at position L and above are zero. L is word_len_i clamped to the range 8..14.
- R6: Mode 4 alternates 14'h2AAA and 14'h1555, and mode 8 alternates 14'h3FFF and 14'h0000. Each starts with the first word of its pair and advances one word per strobe.
- R7: Mode 7 outputs user_words_i[0], [1], [2], [3] in that order, one word per strobe, and then wraps back to [0].
- R8: Mode 6 is a short pseudo-random sequence built from state s[8:0], seeded with 9'h0DF. Each bit time emits s[8] and then shifts in s[8]^s[4]. Each word holds 14 such bits, with the first bit in bit 13. The word length is ignored. The word sequence repeats every 73 words.
- R9: Mode 5 is a long pseudo-random sequence built from state s[22:0], seeded with 23'h29B80A. Each bit time emits the inverse of s[22] and then shifts in s[22]^s[17]. Each word holds 14 bits, with the first bit in bit 13, and the word length is ignored.
- R10: Any change of mode_i from one cycle to the next resets both sequence states to their seeds and resets the word phase to the first word. This takes effect for the first strobe seen with the new mode, even if that strobe comes in the cycle of the change.
- R11: Mode values 9 to 15 output 14'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | One pulse per sample; emits one word |
| mode_i | input | 4 | Pattern select |
| word_len_i | input | 4 | Word length for non-random patterns, 8..14 |
| user_words_i | input | 4x14 | Four user-programmed words, index 0 first |
| sample_i | input | 14 | Converter sample for pass-through |
| word_o | output | 14 | Word handed to the serializer |
| valid_o | output | 1 | High for one cycle after each strobe |

## Verification
The assertions check the following on every cycle:
- the strobe-to-valid timing and that the word holds between strobes;
- the mid-scale value at every word length;
- that no bit above the selected length is set in a shortened pattern;
- that the reserved modes output zero;
- that the user rotation restarts at word 0 after a mode switch.

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a reference model:
- the exact bit sequences of both pseudo-random generators;
- the 73-word repeat of the short sequence;
- that the random modes ignore the word length;
- how the word length is clamped outside 8..14;
- how a switch to another mode and back, made without any strobe in between, restarts a sequence.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_SAMPLE  = 4'd0,
    MODE_MID     = 4'd1,
    MODE_ONES    = 4'd2,
    MODE_ZEROS   = 4'd3,
    MODE_CHECKER = 4'd4,
    MODE_PN_LONG = 4'd5,
    MODE_PN_SHRT = 4'd6,
    MODE_USER    = 4'd7,
    MODE_TOGGLE  = 4'd8
  } tpg_mode_e;
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int unsigned W     = 9,
  parameter int unsigned TAP   = 4,
  parameter logic [W-1:0] SEED = 'h0DF,
  parameter bit          INV   = 1'b0,
  parameter int unsigned OUT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             step_i,
  output logic [OUT_W-1:0] word_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] chain [OUT_W+1];

  assign chain[0] = restart_i ? SEED : state_q;

  // one shift per serial bit time, first bit lands in the MSB
  for (genvar g = 0; g < OUT_W; g++) begin : g_bit
    assign word_o[OUT_W-1-g] = chain[g][W-1] ^ INV;
    assign chain[g+1] = {chain[g][W-2:0], chain[g][W-1] ^ chain[g][TAP]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= chain[OUT_W];
    else             state_q <= chain[0];
  end
endmodule

// File: rtl/tpg_word_sel.sv
module tpg_word_sel
  import tpg_pkg::*;
#(
  parameter int unsigned DW       = 14,
  parameter int unsigned MIN_LEN  = 8,
  parameter int unsigned NUM_USER = 4,
  localparam int unsigned LEN_W   = $clog2(DW + 1),
  localparam int unsigned PH_W    = $clog2(NUM_USER)
) (
  input  logic [MODE_W-1:0]            mode_i,
  input  logic [LEN_W-1:0]             len_i,
  input  logic [PH_W-1:0]              phase_i,
  input  logic [NUM_USER-1:0][DW-1:0]  user_i,
  input  logic [DW-1:0]                sample_i,
  input  logic [DW-1:0]                pn_short_i,
  input  logic [DW-1:0]                pn_long_i,
  output logic [DW-1:0]                word_o
);
  logic [LEN_W-1:0] len_eff;
  logic [LEN_W-1:0] shift;
  logic [DW-1:0]    checker_w;
  logic [DW-1:0]    full;

  always_comb begin
    if (len_i < LEN_W'(MIN_LEN))  len_eff = LEN_W'(MIN_LEN);
    else if (len_i > LEN_W'(DW))  len_eff = LEN_W'(DW);
    else                          len_eff = len_i;
    shift = LEN_W'(DW) - len_eff;
  end

  for (genvar i = 0; i < DW; i++) begin : g_chk
    assign checker_w[i] = ((DW - 1 - i) % 2) == 0;
  end

  always_comb begin
    unique case (mode_i)
      MODE_MID:     full = {1'b1, {(DW-1){1'b0}}};
      MODE_ONES:    full = '1;
      MODE_CHECKER: full = phase_i[0] ? ~checker_w : checker_w;
      MODE_USER:    full = user_i[phase_i];
      MODE_TOGGLE:  full = phase_i[0] ? '0 : '1;
      default:      full = '0;
    endcase
    unique case (mode_i)
      MODE_SAMPLE:  word_o = sample_i;
      MODE_PN_SHRT: word_o = pn_short_i;
      MODE_PN_LONG: word_o = pn_long_i;
      default:      word_o = full >> shift;
    endcase
  end
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int unsigned DW             = 14,
  parameter int unsigned MIN_LEN        = 8,
  parameter int unsigned NUM_USER       = 4,   // power of two
  parameter logic [8:0]  PN_SHORT_SEED  = 9'h0DF,
  parameter logic [22:0] PN_LONG_SEED   = 23'h29B80A,
  localparam int unsigned LEN_W         = $clog2(DW + 1),
  localparam int unsigned PH_W          = $clog2(NUM_USER)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         strobe_i,
  input  logic [MODE_W-1:0]            mode_i,
  input  logic [LEN_W-1:0]             word_len_i,
  input  logic [NUM_USER-1:0][DW-1:0]  user_words_i,
  input  logic [DW-1:0]                sample_i,
  output logic [DW-1:0]                word_o,
  output logic                         valid_o
);
  logic [MODE_W-1:0] mode_q;
  logic [PH_W-1:0]   phase_q, phase_eff;
  logic              restart;
  logic [DW-1:0]     pn_short_w, pn_long_w, sel_w;

  assign restart   = mode_i != mode_q;
  assign phase_eff = restart ? '0 : phase_q;

  tpg_lfsr #(.W(9), .TAP(4), .SEED(PN_SHORT_SEED), .INV(1'b0), .OUT_W(DW)) i_pn_short (
    .clk_i, .rst_ni, .restart_i(restart),
    .step_i(strobe_i && mode_i == MODE_PN_SHRT), .word_o(pn_short_w)
  );

  tpg_lfsr #(.W(23), .TAP(17), .SEED(PN_LONG_SEED), .INV(1'b1), .OUT_W(DW)) i_pn_long (
    .clk_i, .rst_ni, .restart_i(restart),
    .step_i(strobe_i && mode_i == MODE_PN_LONG), .word_o(pn_long_w)
  );

  tpg_word_sel #(.DW(DW), .MIN_LEN(MIN_LEN), .NUM_USER(NUM_USER)) i_sel (
    .mode_i, .len_i(word_len_i), .phase_i(phase_eff), .user_i(user_words_i),
    .sample_i, .pn_short_i(pn_short_w), .pn_long_i(pn_long_w), .word_o(sel_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      phase_q <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      mode_q  <= mode_i;
      valid_o <= strobe_i;
      if (strobe_i) begin
        word_o  <= sel_w;
        phase_q <= phase_eff + 1'b1;
      end else begin
        phase_q <= phase_eff;
      end
    end
  end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
#(
  parameter int unsigned DW       = 14,
  parameter int unsigned MIN_LEN  = 8,
  parameter int unsigned NUM_USER = 4,
  localparam int unsigned LEN_W   = $clog2(DW + 1)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         strobe_i,
  input logic [MODE_W-1:0]            mode_i,
  input logic [LEN_W-1:0]             word_len_i,
  input logic [NUM_USER-1:0][DW-1:0]  user_words_i,
  input logic [DW-1:0]                word_o,
  input logic                         valid_o
);
  logic [LEN_W-1:0]  len_c;
  logic [MODE_W-1:0] prev_mode_q;
  logic              trimmed_mode;

  assign len_c = (word_len_i < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) :
                 (word_len_i > LEN_W'(DW))      ? LEN_W'(DW) : word_len_i;
  assign trimmed_mode = mode_i inside {MODE_MID, MODE_ONES, MODE_ZEROS,
                                       MODE_CHECKER, MODE_USER, MODE_TOGGLE};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_mode_q <= '0;
    else         prev_mode_q <= mode_i;
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> (word_o == '0 && !valid_o));

  a_r2_valid_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> valid_o);

  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !valid_o);

  a_r2_word_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(word_o));

  a_r4_midscale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i == MODE_MID) |=> word_o == (DW'(1) << ($past(len_c) - 1'b1)));

  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && trimmed_mode) |=> (word_o >> $past(len_c)) == '0);

  a_r10_user_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i == MODE_USER && mode_i != prev_mode_q)
    |=> word_o == ($past(user_words_i[0]) >> (LEN_W'(DW) - $past(len_c))));

  a_r11_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i > MODE_TOGGLE) |=> word_o == '0);
endmodule

bind adc_test_pattern_gen tpg_checker #(.DW(DW), .MIN_LEN(MIN_LEN), .NUM_USER(NUM_USER)) i_tpg_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .mode_i(mode_i),
  .word_len_i(word_len_i), .user_words_i(user_words_i), .word_o(word_o), .valid_o(valid_o)
);

// File: tb/test_adc_test_pattern_gen.sv
module test_adc_test_pattern_gen;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             strobe = 1'b0;
  logic [3:0]       mode = 4'd0;
  logic [3:0]       wlen = 4'd14;
  logic [3:0][13:0] user;
  logic [13:0]      sample = '0;
  logic [13:0]      word;
  logic             valid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_test_pattern_gen i_adc_test_pattern_gen (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .mode_i(mode),
    .word_len_i(wlen), .user_words_i(user), .sample_i(sample),
    .word_o(word), .valid_o(valid)
  );

  // ---------------- reference model ----------------
  int m_last = 0, ph = 0, p9 = 'h0DF, p23 = 'h29B80A;
  int exp_word = 0;
  bit exp_valid = 0;

  function automatic int clamp_len(int l);
    if (l < 8) return 8;
    if (l > 14) return 14;
    return l;
  endfunction

  function automatic int trim(int full, int l);
    return full >> (14 - clamp_len(l));
  endfunction

  function automatic int pn9_word(int s);
    int w = 0;
    for (int k = 0; k < 14; k++) begin
      w = (w << 1) | ((s >> 8) & 1);
      s = ((s << 1) & 'h1FF) | (((s >> 8) ^ (s >> 4)) & 1);
    end
    return w;
  endfunction

  function automatic int pn9_adv(int s);
    for (int k = 0; k < 14; k++) s = ((s << 1) & 'h1FF) | (((s >> 8) ^ (s >> 4)) & 1);
    return s;
  endfunction

  function automatic int pn23_word(int s);
    int w = 0;
    for (int k = 0; k < 14; k++) begin
      w = (w << 1) | (((s >> 22) & 1) ^ 1);
      s = ((s << 1) & 'h7FFFFF) | (((s >> 22) ^ (s >> 17)) & 1);
    end
    return w;
  endfunction

  function automatic int pn23_adv(int s);
    for (int k = 0; k < 14; k++) s = ((s << 1) & 'h7FFFFF) | (((s >> 22) ^ (s >> 17)) & 1);
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_last = 0; ph = 0; p9 = 'h0DF; p23 = 'h29B80A; exp_word = 0; exp_valid = 0;
    end else begin
      if (int'(mode) != m_last) begin p9 = 'h0DF; p23 = 'h29B80A; ph = 0; end
      exp_valid = strobe;
      if (strobe) begin
        case (mode)
          4'd0: exp_word = sample;
          4'd1: exp_word = trim('h2000, wlen);
          4'd2: exp_word = trim('h3FFF, wlen);
          4'd3: exp_word = 0;
          4'd4: exp_word = trim((ph % 2) ? 'h1555 : 'h2AAA, wlen);
          4'd5: begin exp_word = pn23_word(p23); p23 = pn23_adv(p23); end
          4'd6: begin exp_word = pn9_word(p9); p9 = pn9_adv(p9); end
          4'd7: exp_word = trim(user[ph % 4], wlen);
          4'd8: exp_word = trim((ph % 2) ? 'h0000 : 'h3FFF, wlen);
          default: exp_word = 0;
        endcase
        ph = (ph + 1) % 4;
      end
      m_last = mode;
    end
  end

  function automatic string tag_of(int m);
    case (m)
      0: return "R3";  1, 2, 3: return "R4/R5";  4, 8: return "R6";
      5: return "R9";  6: return "R8";  7: return "R7";  default: return "R11";
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (valid !== exp_valid) begin
        errors++;
        $display("FAIL R2 valid actual=%0b expected=%0b", valid, exp_valid);
      end
      checks++;
      if (int'(word) !== exp_word) begin
        errors++;
        $display("FAIL %s R10 mode=%0d word actual=%h expected=%h", tag_of(m_last), m_last, word, exp_word[13:0]);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int cap[$];

  task automatic run(int m, int l, int n, int gap, bit record = 0);
    mode = 4'(m); wlen = 4'(l);
    for (int i = 0; i < n; i++) begin
      strobe = 1'b1;
      sample = 14'($urandom);
      @(negedge clk);
      if (record) cap.push_back(int'(word));
      if (gap > 0) begin
        strobe = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    user[0] = 14'h1234; user[1] = 14'h2BCD; user[2] = 14'h0F0F; user[3] = 14'h3801;
    repeat (3) @(negedge clk);
    check("R1 word in reset", int'(word), 0);
    check("R1 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(0, 8, 10, 0);                       // R3 pass-through, length ignored
    run(1, 8, 3, 1);  run(1, 11, 3, 0); run(1, 14, 2, 2);   // R4
    run(2, 3, 3, 0);  run(2, 15, 3, 1); run(2, 10, 2, 0);   // R5 clamping
    run(3, 12, 3, 0);
    run(4, 14, 6, 0); run(4, 9, 5, 3);      // R6
    run(8, 13, 6, 1);
    run(7, 14, 9, 0); run(7, 8, 6, 2);      // R7
    cap.delete();
    run(6, 8, 80, 0, 1);                    // R8, length ignored
    check("R8 first word equals word 73", cap[73], cap[0]);
    check("R8 word 1 differs from word 0", int'(cap[1] != cap[0]), 1);
    run(5, 8, 40, 1);                       // R9
    run(6, 14, 5, 0); run(7, 10, 3, 0); run(6, 14, 5, 0);   // R10
    run(5, 14, 4, 0);
    mode = 4'd3; @(negedge clk); run(5, 14, 4, 0);           // R10 change without strobe
    run(4, 14, 3, 0); run(8, 14, 1, 0); run(4, 14, 2, 0);
    for (int m = 9; m < 16; m++) run(m, 14, 2, 0);           // R11
    run(1, 14, 1, 4);                                         // R2 hold across idle cycles

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule